// File: doc/BRIEF.md
# Write-Enable Latch and Protection Unit

This unit sits between the command decoder of a serial non-volatile byte memory and its storage array. It decides, byte by byte, whether an incoming write may change the array, and whether a status-register write may change the configuration bits. It holds three things: a write-enable latch, a two-bit block-protect field, and a write-protect-enable bit. It also samples an active-low hardware write-protect pin.

The serial front end sends single-cycle strobes. One set marks decoded opcodes: set-latch, clear-latch, status write and array write. One strobe carries the status data byte. One strobe marks each array byte together with its address, and one marks the rising edge of chip select. The unit returns a combinational per-byte grant and the status byte used for reads. The latch can only be set by its own command. Any write-type command disarms it again when its chip-select frame ends. Address-range block protection is applied on top of the latch.

The bench drives at most one of the command, data and chip-select strobes in any cycle. The array byte strobe may come in the same cycle as any of them.

Top module: `write_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and no array byte is granted.
- R2: A set-latch strobe (`cmd_wren`) makes status bit 1 read 1 from the next cycle on.
- R3: Bit 1 of an accepted status data byte has no effect on the latch. Only `cmd_wren` can raise status bit 1.
- R4: A `cs_rise` strobe clears the latch from the next cycle when a clear-latch, status-write or array-write opcode strobe has come since the previous `cs_rise`. A `cs_rise` that ends a frame without such a strobe leaves the latch unchanged.
- R5: While the latch is clear, `wr_grant` stays 0 and status data bytes leave status bits 7:2 unchanged.
- R6: The block-protect field is status bits 3:2. With the field at 00 no address is locked. At 01 addresses 0x180 to 0x1FF are locked, at 10 addresses 0x100 to 0x1FF, and at 11 every address. A locked byte is never granted. Any other byte is granted when the latch is set.
- R7: The write-protect enable is status bit 7. When it is 1 and `wp_n` is 0, status data bytes are refused. When `wp_n` is 1 they are accepted, provided the latch is set.
- R8: An accepted status data byte loads its bits 7 and 3:2 into status bits 7 and 3:2. Status bits 6:4 and 0 always read 0.
- R9: The grant is evaluated separately for each byte strobe. A burst that crosses from an unlocked address into a locked one is granted up to the boundary and refused after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Set-latch opcode strobe |
| cmd_wrdi | input | 1 | Clear-latch opcode strobe |
| cmd_wrsr | input | 1 | Status-write opcode strobe |
| cmd_write | input | 1 | Array-write opcode strobe |
| cs_rise | input | 1 | Chip-select rising edge strobe |
| sr_wr_valid | input | 1 | Status data byte strobe |
| sr_wdata | input | 8 | Status data byte |
| wr_req | input | 1 | Array byte strobe |
| wr_addr | input | 9 | Byte address of the array byte |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| wr_grant | output | 1 | The array byte at `wr_addr` may be written |
| status_byte | output | 8 | Status byte for reads |

## Verification
The assertions check four rules in every cycle:
- the latch is raised only by a set-latch strobe, and it drops after a chip-select rise that ends a write-type frame;
- no grant is ever given with the latch clear or with the whole array locked;
- the configuration bits hold when a status byte arrives with the latch clear;
- the configuration bits hold when a status byte arrives while hardware protection is active.

Only the bench scenarios can show the exact lock boundaries of each block-protect setting. The same holds for a burst stepping across such a boundary. They also show that latch bit 1 in a status data byte is ignored, and that a chip-select rise after a frame with only the set-latch opcode leaves the latch set.

// File: rtl/write_guard_pkg.sv
package write_guard_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_sel_t;

  // Decide from the two most significant address bits whether a byte is locked.
  function automatic logic region_locked(input lock_sel_t sel, input logic [1:0] top2);
    case (sel)
      LOCK_NONE:    region_locked = 1'b0;
      LOCK_QUARTER: region_locked = (top2 == 2'b11);
      LOCK_HALF:    region_locked = top2[1];
      default:      region_locked = 1'b1;
    endcase
  endfunction

  // Assemble the readable status byte.
  function automatic logic [7:0] pack_status(input logic wpen, input lock_sel_t sel,
                                             input logic wel);
    pack_status = {wpen, 3'b000, sel, wel, 1'b0};
  endfunction

endpackage

// File: rtl/write_guard_latch.sv
module write_guard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_strobe,
  input  logic write_type_strobe,
  input  logic frame_end,
  output logic wel,
  output logic write_open
);

  logic disarm_now;
  assign disarm_now = frame_end && write_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (disarm_now) begin
      wel <= 1'b0;
    end else if (set_strobe) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_open <= 1'b0;
    end else if (frame_end) begin
      write_open <= 1'b0;
    end else if (write_type_strobe) begin
      write_open <= 1'b1;
    end
  end

endmodule

// File: rtl/write_guard_config.sv
module write_guard_config
  import write_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_valid,
  input  logic [7:0] load_data,
  input  logic       wel,
  input  logic       wp_n,
  output logic       load_accept,
  output lock_sel_t  lock_sel,
  output logic       wpen
);

  logic hw_block;
  logic unused_load_bits;

  assign hw_block         = wpen && !wp_n;
  assign load_accept      = load_valid && wel && !hw_block;
  assign unused_load_bits = ^{load_data[6:4], load_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_sel <= LOCK_NONE;
      wpen     <= 1'b0;
    end else if (load_accept) begin
      lock_sel <= lock_sel_t'(load_data[3:2]);
      wpen     <= load_data[7];
    end
  end

endmodule

// File: rtl/write_guard_region.sv
module write_guard_region
  import write_guard_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  lock_sel_t         lock_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);

  localparam int TOP_LSB = ADDR_W - 2;

  logic [1:0] top2;
  logic       unused_low_addr;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign top2            = addr[ADDR_W-1:TOP_LSB];
      assign unused_low_addr = ^addr[TOP_LSB-1:0];
    end else begin : g_narrow
      assign top2            = addr[1:0];
      assign unused_low_addr = 1'b0;
    end
  endgenerate

  assign locked = region_locked(lock_sel, top2);

endmodule

// File: rtl/write_guard.sv
module write_guard
  import write_guard_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic              cs_rise,
  input  logic              sr_wr_valid,
  input  logic [7:0]        sr_wdata,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_n,
  output logic              wr_grant,
  output logic [7:0]        status_byte
);

  logic      wel;
  logic      write_open;
  logic      write_type_strobe;
  logic      sr_accept;
  logic      addr_locked;
  logic      wpen;
  lock_sel_t lock_sel;

  assign write_type_strobe = cmd_wrdi || cmd_wrsr || cmd_write;

  write_guard_latch u_latch (
    .clk               (clk),
    .rst_n             (rst_n),
    .set_strobe        (cmd_wren),
    .write_type_strobe (write_type_strobe),
    .frame_end         (cs_rise),
    .wel               (wel),
    .write_open        (write_open)
  );

  write_guard_config u_config (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (sr_wr_valid),
    .load_data   (sr_wdata),
    .wel         (wel),
    .wp_n        (wp_n),
    .load_accept (sr_accept),
    .lock_sel    (lock_sel),
    .wpen        (wpen)
  );

  write_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .lock_sel (lock_sel),
    .addr     (wr_addr),
    .locked   (addr_locked)
  );

  assign wr_grant    = wr_req && wel && !addr_locked;
  assign status_byte = pack_status(wpen, lock_sel, wel);

endmodule

// File: rtl/write_guard_chk.sv
module write_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cs_rise,
  input logic       sr_wr_valid,
  input logic       wp_n,
  input logic       write_open,
  input logic       wr_grant,
  input logic [7:0] status_byte
);

  // R2
  wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !cs_rise) |=> status_byte[1]);

  // R3
  wel_rise_only_by_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_byte[1] && !cmd_wren) |=> !status_byte[1]);

  // R4
  frame_end_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && write_open) |=> !status_byte[1]);

  // R5
  no_grant_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> status_byte[1]);

  // R5
  sr_hold_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_valid && !status_byte[1]) |=> $stable(status_byte[7:2]));

  // R6
  lock_all_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !wr_grant);

  // R7
  hw_protect_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_valid && status_byte[7] && !wp_n) |=> $stable(status_byte[7:2]));

endmodule

bind write_guard write_guard_chk u_write_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wren    (cmd_wren),
  .cs_rise     (cs_rise),
  .sr_wr_valid (sr_wr_valid),
  .wp_n        (wp_n),
  .write_open  (write_open),
  .wr_grant    (wr_grant),
  .status_byte (status_byte)
);

// File: tb/write_guard_bench.sv
`timescale 1ns/1ps
module write_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0;
  logic       cs_rise = 1'b0, sr_wr_valid = 1'b0, wr_req = 1'b0, wp_n = 1'b1;
  logic [7:0] sr_wdata = 8'h00;
  logic [8:0] wr_addr = 9'h000;
  logic       wr_grant;
  logic [7:0] status_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Independent model of the documented behaviour.
  bit       m_wel = 1'b0, m_open = 1'b0, m_wpen = 1'b0;
  bit [1:0] m_bp = 2'b00;

  always #4 clk = ~clk;

  write_guard u_write_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write), .cs_rise(cs_rise),
    .sr_wr_valid(sr_wr_valid), .sr_wdata(sr_wdata), .wr_req(wr_req),
    .wr_addr(wr_addr), .wp_n(wp_n), .wr_grant(wr_grant), .status_byte(status_byte)
  );

  function automatic bit exp_locked(input bit [1:0] bp, input bit [8:0] a);
    int quarter = int'(a) / 128;
    case (bp)
      2'd0: return 1'b0;
      2'd1: return quarter == 3;
      2'd2: return quarter >= 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] exp_status();
    bit [7:0] s = 8'h00;
    s[7] = m_wpen;
    s[3] = m_bp[1];
    s[2] = m_bp[0];
    s[1] = m_wel;
    return s;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle of stimulus; op: 0 idle,1 wren,2 wrdi,3 wrsr,4 write,5 cs_rise,6 sr data
  task automatic step(input int op, input logic [7:0] d, input bit req,
                      input logic [8:0] a, input bit wp, input string gtag,
                      input string stag);
    bit acc;
    bit g_exp;
    @(negedge clk);
    cmd_wren = (op == 1); cmd_wrdi = (op == 2); cmd_wrsr = (op == 3);
    cmd_write = (op == 4); cs_rise = (op == 5); sr_wr_valid = (op == 6);
    sr_wdata = d; wr_req = req; wr_addr = a; wp_n = wp;
    #1;
    g_exp = req && m_wel && !exp_locked(m_bp, a);
    if (req) check(gtag, {7'b0, wr_grant}, {7'b0, g_exp});
    @(posedge clk);
    #1;
    acc = (op == 6) && m_wel && !(m_wpen && !wp);
    if (acc) begin
      m_wpen = d[7];
      m_bp = d[3:2];
    end
    if (op == 5) begin
      if (m_open) m_wel = 1'b0;
      m_open = 1'b0;
    end else begin
      if (op == 1) m_wel = 1'b1;
      if (op == 2 || op == 3 || op == 4) m_open = 1'b1;
    end
    check(stag, status_byte, exp_status());
  endtask

  task automatic set_config(input logic [7:0] d);
    step(1, 8'h00, 0, 9'h0, 1, "R2", "R2");
    step(3, 8'h00, 0, 9'h0, 1, "R5", "R8");
    step(6, d, 0, 9'h0, 1, "R5", "R8");
    step(5, 8'h00, 0, 9'h0, 1, "R5", "R4");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", status_byte, 8'h00);
    wr_req = 1'b1; wr_addr = 9'h000;
    #1;
    check("R1", {7'b0, wr_grant}, 8'h00);
    wr_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R5: no latch -> refused write, status data ignored
    step(4, 8'h00, 1, 9'h010, 1, "R5", "R5");
    step(6, 8'h8c, 0, 9'h0, 1, "R5", "R5");
    step(5, 8'h00, 0, 9'h0, 1, "R5", "R5");
    // R2 then R4: cs_rise after a frame with only set-latch keeps the latch
    step(1, 8'h00, 0, 9'h0, 1, "R2", "R2");
    step(5, 8'h00, 0, 9'h0, 1, "R4", "R4");
    check("R4", {7'b0, status_byte[1]}, 8'h01);
    // R3: status data with bit1 = 0 leaves the latch set
    step(3, 8'h00, 0, 9'h0, 1, "R3", "R3");
    step(6, 8'hf1, 0, 9'h0, 1, "R3", "R8");
    check("R3", {7'b0, status_byte[1]}, 8'h01);
    check("R8", status_byte, 8'h82);
    step(5, 8'h00, 0, 9'h0, 1, "R4", "R4");
    check("R4", {7'b0, status_byte[1]}, 8'h00);
    // R3: latch clear, status data with bit1 = 1 must not raise it
    step(6, 8'h02, 0, 9'h0, 1, "R3", "R3");
    check("R3", {7'b0, status_byte[1]}, 8'h00);
    // R7: wpen set and pin low refuses; pin high accepts
    step(1, 8'h00, 0, 9'h0, 1, "R7", "R7");
    step(3, 8'h00, 0, 9'h0, 0, "R7", "R7");
    step(6, 8'h04, 0, 9'h0, 0, "R7", "R7");
    check("R7", status_byte, 8'h82);
    step(6, 8'h84, 0, 9'h0, 1, "R7", "R7");
    check("R7", status_byte, 8'h86);
    step(5, 8'h00, 0, 9'h0, 1, "R4", "R4");
    // R6 / R9: quarter lock burst across 0x180
    step(1, 8'h00, 0, 9'h0, 1, "R6", "R6");
    step(4, 8'h00, 1, 9'h17e, 1, "R9", "R9");
    step(0, 8'h00, 1, 9'h17f, 1, "R9", "R9");
    step(0, 8'h00, 1, 9'h180, 1, "R9", "R9");
    step(0, 8'h00, 1, 9'h181, 1, "R9", "R9");
    step(5, 8'h00, 0, 9'h0, 1, "R4", "R4");
    // R6: each lock setting at its boundaries
    for (int s = 0; s < 4; s++) begin
      set_config({4'b0000, s[1:0], 2'b00});
      step(1, 8'h00, 0, 9'h0, 1, "R6", "R6");
      step(4, 8'h00, 1, 9'h0ff, 1, "R6", "R6");
      step(0, 8'h00, 1, 9'h100, 1, "R6", "R6");
      step(0, 8'h00, 1, 9'h17f, 1, "R6", "R6");
      step(0, 8'h00, 1, 9'h1ff, 1, "R6", "R6");
      step(0, 8'h00, 1, 9'h000, 1, "R6", "R6");
      step(5, 8'h00, 0, 9'h0, 1, "R4", "R4");
    end

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15) op = 1;
      else if (r < 22) op = 2;
      else if (r < 32) op = 3;
      else if (r < 45) op = 4;
      else if (r < 60) op = 5;
      else if (r < 75) op = 6;
      else op = 0;
      step(op, 8'($urandom()), 1'($urandom()), 9'($urandom()),
           ($urandom_range(0, 3) != 0), "R9", "R8");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule